// File: doc/BRIEF.md
# Partitioned pixel multiply unit

This block scales packed 8-bit pixel components by signed 16-bit factors. It takes two 64-bit operand vectors: a pixel vector of eight bytes and a scale vector of four signed halfwords. A 3-bit mode chooses how the two vectors are paired into lanes. Each lane forms a 32-bit signed product and rounds it to nearest. Narrow modes keep bits 23..8 of the rounded product in four 16-bit result lanes. Wide modes keep the whole rounded product in two 32-bit result lanes.

All modes share one datapath. An operand selector picks each lane's 8-bit factor, extended to 9 bits, and its 16-bit scale. Four lane multipliers feed a first register stage. A round-and-pack stage then feeds the output register. One operand set is accepted every cycle, and a result leaves two cycles after it entered. Lane 0 always occupies the least significant bits of every vector.

The operating modes act as the states of the selector. They are lanewise (0), broadcast-halfword-1 (1), broadcast-halfword-0 (2), high-byte-signed (3), low-byte-unsigned (4), wide-high-byte-signed (5), wide-low-byte-unsigned (6) and reserved (7). Each accepted operand set moves the pipeline through two transitions: capture (input to stage 1) and retire (stage 1 to output).

Top module: `pmul_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0.
- R2: `out_valid` is high exactly two clock cycles after a cycle in which `in_valid` was high, and is low otherwise.
- R3: Mode 0: result lane r (bits 16r+15..16r) uses unsigned pixel byte r (bits 8r+7..8r) times signed scale halfword r (bits 16r+15..16r), for r = 0..3.
- R4: Mode 1: as mode 0, except that every lane uses signed scale halfword 1 (bits 31..16).
- R5: Mode 2: as mode 0, except that every lane uses signed scale halfword 0 (bits 15..0).
- R6: Mode 3: lane r's 8-bit factor is pixel bits 16r+15..16r+8 taken as a signed value, times signed scale halfword r, for four 16-bit lanes.
- R7: Mode 4: lane r's 8-bit factor is pixel bits 16r+7..16r+0 taken as unsigned, times signed scale halfword r, for four 16-bit lanes.
- R8: Rounding: take the 32-bit two's-complement product P. If P[7:0] > 0x7F, add 0x100 to P. A narrow lane's result is bits 23..8 of that sum, so a low byte of 0x80 rounds up and 0x7F does not.
- R9: Mode 5: lanes 0 and 1 are formed as in mode 3. Each writes its full 32-bit rounded product (R8 without the shift) into result bits 32r+31..32r.
- R10: Mode 6: lanes 0 and 1 are formed as in mode 4. Each writes its full 32-bit rounded product into result bits 32r+31..32r.
- R11: Mode 7 produces an all-zero result, still marked valid per R2.
- R12: `out_data` keeps its value in every cycle in which no new result is delivered.
- R13: Operand sets presented on consecutive cycles are all accepted, and their results appear on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_mode | input | 3 | Lane-pairing mode, 0..7 |
| in_pix | input | 64 | Pixel vector, eight bytes, byte 0 in bits 7..0 |
| in_scale | input | 64 | Scale vector, four signed halfwords, halfword 0 in bits 15..0 |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Four 16-bit lanes or two 32-bit lanes |

## Verification
Every result and its valid flag are due exactly two rising edges after the edge that captures the operand set. The bench drives inputs on falling edges and keeps a two-deep history of the valid flag and the arithmetic expected value. At each falling edge it compares the outputs against the entry from two falling edges earlier. On cycles with no expected result, it compares `out_data` against the value it read one falling edge before, which covers R12.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [2:0] {
        PM_LANEWISE  = 3'd0,
        PM_BCAST_H1  = 3'd1,
        PM_BCAST_H0  = 3'd2,
        PM_HIBYTE_S  = 3'd3,
        PM_LOBYTE_U  = 3'd4,
        PM_WIDE_HI_S = 3'd5,
        PM_WIDE_LO_U = 3'd6,
        PM_RESERVED  = 3'd7
    } pm_mode_e;

    function automatic logic pm_is_wide(pm_mode_e m);
        return (m == PM_WIDE_HI_S) || (m == PM_WIDE_LO_U);
    endfunction

endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
    import pmul_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int PIX_W = 8,
    localparam int SCL_W = 2 * PIX_W,
    localparam int VEC_W = LANES * SCL_W
) (
    input  pm_mode_e                      mode,
    input  logic [VEC_W-1:0]              pix,
    input  logic [VEC_W-1:0]              scl,
    output logic [LANES-1:0][PIX_W:0]     factor,
    output logic [LANES-1:0][SCL_W-1:0]   scale,
    output logic [LANES-1:0]              lane_en,
    output logic                          wide
);
    localparam int WIDE_LANES = LANES / 2;

    assign wide = pm_is_wide(mode);

    for (genvar r = 0; r < LANES; r++) begin : g_lane
        logic [PIX_W-1:0] own_byte;
        logic [PIX_W-1:0] hw_hi_byte;
        logic [PIX_W-1:0] hw_lo_byte;
        logic [SCL_W-1:0] own_scale;
        localparam bit IN_WIDE = (r < WIDE_LANES);

        assign own_byte   = pix[r*PIX_W +: PIX_W];
        assign hw_hi_byte = pix[r*SCL_W + PIX_W +: PIX_W];
        assign hw_lo_byte = pix[r*SCL_W +: PIX_W];
        assign own_scale  = scl[r*SCL_W +: SCL_W];

        always_comb begin
            unique case (mode)
                PM_LANEWISE: begin
                    factor[r]  = {1'b0, own_byte};
                    scale[r]   = own_scale;
                    lane_en[r] = 1'b1;
                end
                PM_BCAST_H1: begin
                    factor[r]  = {1'b0, own_byte};
                    scale[r]   = scl[SCL_W +: SCL_W];
                    lane_en[r] = 1'b1;
                end
                PM_BCAST_H0: begin
                    factor[r]  = {1'b0, own_byte};
                    scale[r]   = scl[0 +: SCL_W];
                    lane_en[r] = 1'b1;
                end
                PM_HIBYTE_S: begin
                    factor[r]  = {hw_hi_byte[PIX_W-1], hw_hi_byte};
                    scale[r]   = own_scale;
                    lane_en[r] = 1'b1;
                end
                PM_LOBYTE_U: begin
                    factor[r]  = {1'b0, hw_lo_byte};
                    scale[r]   = own_scale;
                    lane_en[r] = 1'b1;
                end
                PM_WIDE_HI_S: begin
                    factor[r]  = {hw_hi_byte[PIX_W-1], hw_hi_byte};
                    scale[r]   = own_scale;
                    lane_en[r] = IN_WIDE;
                end
                PM_WIDE_LO_U: begin
                    factor[r]  = {1'b0, hw_lo_byte};
                    scale[r]   = own_scale;
                    lane_en[r] = IN_WIDE;
                end
                PM_RESERVED: begin
                    factor[r]  = '0;
                    scale[r]   = '0;
                    lane_en[r] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult #(
    parameter  int PIX_W  = 8,
    localparam int SCL_W  = 2 * PIX_W,
    localparam int PROD_W = 4 * PIX_W
) (
    input  logic [PIX_W:0]    factor,
    input  logic [SCL_W-1:0]  scale,
    input  logic              enable,
    output logic [PROD_W-1:0] product
);
    localparam int MUL_W = PIX_W + 1 + SCL_W;

    logic signed [PIX_W:0]   f_s;
    logic signed [SCL_W-1:0] s_s;
    logic signed [MUL_W-1:0] raw;

    assign f_s = $signed(factor);
    assign s_s = $signed(scale);
    assign raw = MUL_W'(f_s) * MUL_W'(s_s);

    always_comb begin
        if (enable) begin
            product = {{(PROD_W - MUL_W){raw[MUL_W-1]}}, raw};
        end else begin
            product = '0;
        end
    end

endmodule

// File: rtl/pmul_round_pack.sv
module pmul_round_pack #(
    parameter  int LANES  = 4,
    parameter  int PIX_W  = 8,
    localparam int SCL_W  = 2 * PIX_W,
    localparam int PROD_W = 4 * PIX_W,
    localparam int VEC_W  = LANES * SCL_W
) (
    input  logic [LANES-1:0][PROD_W-1:0] prod,
    input  logic                         wide,
    output logic [VEC_W-1:0]             packed_out
);
    localparam int WIDE_LANES = LANES / 2;

    logic [VEC_W-1:0] narrow_vec;
    logic [VEC_W-1:0] wide_vec;

    for (genvar r = 0; r < LANES; r++) begin : g_lane
        logic [PROD_W-1:0] bump;
        logic [PROD_W-1:0] rounded;

        assign bump    = {{(PROD_W - PIX_W - 1){1'b0}}, prod[r][PIX_W-1], {PIX_W{1'b0}}};
        assign rounded = prod[r] + bump;
        assign narrow_vec[r*SCL_W +: SCL_W] = rounded[PIX_W +: SCL_W];

        if (r < WIDE_LANES) begin : g_wide
            assign wide_vec[r*PROD_W +: PROD_W] = rounded;
        end else begin : g_narrow_only
            logic lane_unused;
            assign lane_unused = ^{rounded[PROD_W-1:PIX_W+SCL_W], rounded[PIX_W-1:0]};
        end
    end

    assign packed_out = wide ? wide_vec : narrow_vec;

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
    import pmul_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int PIX_W  = 8,
    localparam int SCL_W  = 2 * PIX_W,
    localparam int PROD_W = 4 * PIX_W,
    localparam int VEC_W  = LANES * SCL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_mode,
    input  logic [VEC_W-1:0] in_pix,
    input  logic [VEC_W-1:0] in_scale,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    pm_mode_e                     mode_q;
    logic [LANES-1:0][PIX_W:0]    sel_factor;
    logic [LANES-1:0][SCL_W-1:0]  sel_scale;
    logic [LANES-1:0]             sel_en;
    logic                         sel_wide;
    logic [LANES-1:0][PROD_W-1:0] mul_prod;

    logic                         s1_valid;
    logic                         s1_wide;
    logic [LANES-1:0][PROD_W-1:0] s1_prod;
    logic [VEC_W-1:0]             packed_res;

    assign mode_q = pm_mode_e'(in_mode);

    pmul_operand_sel #(.LANES(LANES), .PIX_W(PIX_W)) u_sel (
        .mode    (mode_q),
        .pix     (in_pix),
        .scl     (in_scale),
        .factor  (sel_factor),
        .scale   (sel_scale),
        .lane_en (sel_en),
        .wide    (sel_wide)
    );

    for (genvar r = 0; r < LANES; r++) begin : g_mul
        pmul_lane_mult #(.PIX_W(PIX_W)) u_mul (
            .factor  (sel_factor[r]),
            .scale   (sel_scale[r]),
            .enable  (sel_en[r]),
            .product (mul_prod[r])
        );
    end

    // Stage 1: capture products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_wide  <= 1'b0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_wide <= sel_wide;
                s1_prod <= mul_prod;
            end
        end
    end

    pmul_round_pack #(.LANES(LANES), .PIX_W(PIX_W)) u_pack (
        .prod       (s1_prod),
        .wide       (s1_wide),
        .packed_out (packed_res)
    );

    // Stage 2: output register, held while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= packed_res;
            end
        end
    end

endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
    parameter int VEC_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_mode,
    input logic             s1_valid,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid) |-> $past(in_valid, 2)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_data)); // R12

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid && $past(in_valid, 2) && $past(in_mode, 2) == 3'd7)
        |-> out_data == '0); // R11

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && age >= 2'd1) |=> (s1_valid && out_valid)); // R13

endmodule

bind pmul_unit pmul_unit_chk #(.VEC_W(VEC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_pmul_unit.sv
`timescale 1ns/1ps
module test_pmul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = 3'd0;
    logic [63:0] in_pix = '0;
    logic [63:0] in_scale = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // two-deep history of what was driven
    bit          hv0 = 1'b0, hv1 = 1'b0;
    logic [63:0] he0 = '0, he1 = '0;
    string       ht0 = "", ht1 = "";
    logic [63:0] last_q = '0;

    always #2 clk = ~clk;

    pmul_unit i_pmul_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_pix(in_pix), .in_scale(in_scale), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] scl_pick(int i);
        case (i & 15)
            0: return 16'h0000;   1: return 16'h0001;
            2: return 16'h7FFF;   3: return 16'h8000;
            4: return 16'hFFFF;   5: return 16'h0100;
            6: return 16'h00FF;   7: return 16'h1234;
            8: return 16'hFEDC;   9: return 16'h0080;
            10: return 16'h4000;  11: return 16'hC000;
            12: return 16'h7F80;  13: return 16'h8080;
            14: return 16'hFF81;  default: return 16'h007F;
        endcase
    endfunction

    function automatic string mtag(int m);
        case (m)
            0: return "R3 lanewise";
            1: return "R4 bcast hw1";
            2: return "R5 bcast hw0";
            3: return "R6 high byte signed";
            4: return "R7 low byte unsigned";
            5: return "R9 wide signed";
            6: return "R10 wide unsigned";
            default: return "R11 reserved";
        endcase
    endfunction

    // Arithmetic model built from the requirements (R3..R11, rounding R8)
    function automatic logic [63:0] model(int m, logic [63:0] a, logic [63:0] b);
        logic [63:0] res = '0;
        for (int l = 0; l < 4; l++) begin
            int f, s, p;
            logic [15:0] hw;
            hw = b[l*16 +: 16];
            if (m == 1) hw = b[31:16];
            if (m == 2) hw = b[15:0];
            s = int'($signed(hw));
            case (m)
                0, 1, 2: f = int'(a[l*8 +: 8]);
                3, 5:    f = int'($signed(a[l*16+8 +: 8]));
                4, 6:    f = int'(a[l*16 +: 8]);
                default: f = 0;
            endcase
            p = f * s;
            if ((p & 255) > 127) p = p + 256;
            if (m == 5 || m == 6) begin
                if (l < 2) res[l*32 +: 32] = p;
            end else if (m < 5) begin
                res[l*16 +: 16] = p[23:8];
            end
        end
        return res;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [2:0] m, logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        check("R2/R13 valid timing", {63'b0, out_valid}, {63'b0, hv1});
        if (hv1) check(ht1, out_data, he1);
        else     check("R12 hold", out_data, last_q);
        last_q = out_data;
        hv1 = hv0; he1 = he0; ht1 = ht0;
        hv0 = v;   he0 = model(int'(m), a, b); ht0 = tag;
        in_valid = v; in_mode = m; in_pix = a; in_scale = b;
    endtask

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'b0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;

        // R8 directed rounding edges: low byte 0x80 rounds up, 0x7F does not
        step(1'b1, 3'd0, 64'h0101_0101_0101_0101, 64'hFF81_FF80_007F_0080, "R8 rounding narrow");
        step(1'b1, 3'd6, 64'h0001_0001_0001_0001, 64'h0000_0000_FF80_0080, "R8 rounding wide");
        step(1'b1, 3'd3, 64'hFF00_8000_7F00_0100, 64'h0080_FF80_007F_0081, "R8 rounding signed");
        step(1'b0, 3'd0, '0, '0, "idle");

        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 256; p++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [63:0] a, b;
                    for (int bi = 0; bi < 8; bi++) a[bi*8 +: 8] = 8'(p + 37*bi + 11*k);
                    for (int j = 0; j < 4; j++) b[j*16 +: 16] = scl_pick(3*k + 5*j + p);
                    n++;
                    if (n % 7 == 0) step(1'b0, 3'(m + 3), ~a, b ^ 64'h5A5A, "R12 idle");
                    else            step(1'b1, 3'(m), a, b, mtag(m));
                end
            end
        end
        step(1'b0, 3'd0, '0, '0, "flush");
        step(1'b0, 3'd0, '0, '0, "flush");
        step(1'b0, 3'd0, '0, '0, "flush");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule